// File: doc/BRIEF.md
# Register-Driven Serial Chain Shifter

This block is a small command engine that a processor drives through two write ports and reads back through two read ports. It moves data through a long serial configuration chain that lives in a set of lane groups, and it can make a group copy its lane state into the chain (capture) or copy the chain into its lane state (update). A single command moves 1 to 32 bits around a circular path: each serial period the lowest bit of a 32-bit working register goes into the chain of every selected group, and the bit leaving the chain of the group picked by the return selector comes back in at the top of the same register. A group marked as bypassed is replaced in the path by a one-bit stage, so its own chain and lane state stay put.

A configuration register holds the serial clock divide setting, the return selector and a per-group bypass mask. A command register holds the working data, a bit count, three request bits (shift, capture, update) and a one-hot group select. The request bit of the running operation reads back as 1 until the operation ends, so software polls it as a busy flag. The serial clock runs only during an operation and idles low. The lane-side chain of each group is modelled as a shift register plus a parallel lane state of the same length.

The controller has four states: IDLE, SHIFT, CAPTURE and UPDATE. IDLE goes to SHIFT, CAPTURE or UPDATE on a command write with exactly one request bit set; SHIFT returns to IDLE at the end of the serial period that moves the last counted bit; CAPTURE and UPDATE each return to IDLE at the end of their single serial period.

Top module: `chain_cmd_engine`

## Requirements
- R1: After reset both read ports read zero, the serial clock is low, every chain holds zeros, every bypass stage holds 0, and bit i of every group's lane state is 1 exactly when i is a multiple of 3.
- R2: During an operation one serial period lasts 2^(D+2) system clocks, where D is configuration bits [2:0]; the serial clock is low for the first half of each period and high for the second half, and it is low whenever no operation runs.
- R3: A command write with only bit 40 set starts a shift of C+1 bits, C being command bits [36:32]; bit 40 reads back as 1 for exactly (C+1)*2^(D+2) clocks and then clears.
- R4: The working register is command bits [31:0]; its bit 0 leaves first, each step moves it right by one and the returned bit enters at bit 31, so after n steps the upper n bits hold the returned bits (oldest lowest) and the lower bits hold the original data shifted right by n.
- R5: A chain is LANES*LANE_BITS bits long; a bit shifted into a non-bypassed group leaves it again after exactly that many further shifts, in order.
- R6: A write with only bit 41 set runs a capture lasting one serial period, which loads each selected non-bypassed group's chain from its lane state.
- R7: A write with only bit 42 set runs an update lasting one serial period, which loads each selected non-bypassed group's lane state from its chain.
- R8: Command bits [48+GROUPS-1:48] select the groups an operation acts on (bit g for group g); unselected groups are unchanged, and the returned bit comes from the group whose index is in configuration bits [4+w-1:4], w being the width of a group index.
- R9: When configuration bit 8+g is set, group g's chain and lane state are unchanged by all operations and a one-bit stage takes its place: it returns the bit it received on the previous shift.
- R10: Writes to either register while an operation runs are ignored.
- R11: A command write in IDLE with none or more than one of bits 40..42 set is ignored and leaves the command register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data: divide [2:0], return selector from bit 4, bypass mask from bit 8 |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 64 | Command write data: data [31:0], count [36:32], requests [42:40], select from bit 48 |
| cfg_rdata | output | 32 | Configuration register read-back |
| cmd_rdata | output | 64 | Command register read-back with live working data and busy request bits |
| sclk | output | 1 | Divided serial clock, low while idle |

## Verification
The hardest case to reach from the ports is the interaction of a bypassed group, a return selector pointing at a different group and a multi-bit select, because the only visible evidence is the bit order returned in the top of the working register several commands later. The bench first loads known patterns into a group, then switches bypass and return selection and shifts through other groups, and finally reads the original group back to show its contents survived. Writes landing in the middle of a shift are placed by issuing them a fixed number of clocks after the start, while a behavioural model with per-group bit queues predicts every read-back value and the serial clock on each cycle.

// File: rtl/chain_pkg.sv
package chain_pkg;

    localparam int REG_DATA_W  = 32;
    localparam int REG_CNT_W   = 5;
    localparam int CFG_W       = 32;
    localparam int CMD_W       = 64;
    localparam int MAX_GROUPS  = 8;

    localparam int CMD_CNT_LSB = 32;
    localparam int CMD_SHF_BIT = 40;
    localparam int CMD_CAP_BIT = 41;
    localparam int CMD_UPD_BIT = 42;
    localparam int CMD_SEL_LSB = 48;
    localparam int CFG_MUX_LSB = 4;
    localparam int CFG_BYP_LSB = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_UPDATE  = 2'd3
    } chain_state_e;

endpackage

// File: rtl/serial_clk_div.sv
module serial_clk_div
    import chain_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             sclk_o
);

    localparam int CW = (1 << DIV_W) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = (CW'(1) << (32'(div_i) + 32'd2)) - CW'(1);
        tick_o = run_i && (cnt_q == limit);
        sclk_o = run_i && (cnt_q > (limit >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: a period boundary restarts the phase counter
    p_period_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0))
        else $error("period counter did not wrap");

endmodule

// File: rtl/lane_group_chain.sv
module lane_group_chain #(
    parameter int LANE_BITS = 268,
    parameter int LANES     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic cap_i,
    input  logic upd_i,
    input  logic byp_i,
    input  logic tdi_i,
    output logic tdo_o
);

    localparam int N = LANE_BITS * LANES;

    function automatic logic [N-1:0] lane_seed();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[i] = ((i % 3) == 0);
        end
        return v;
    endfunction

    localparam logic [N-1:0] SEED = lane_seed();

    logic [N-1:0] chain_q;
    logic [N-1:0] lane_q;
    logic         byp_stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q     <= '0;
            lane_q      <= SEED;
            byp_stage_q <= 1'b0;
        end else if (byp_i) begin
            if (shift_i) begin
                byp_stage_q <= tdi_i;
            end
        end else begin
            if (shift_i) begin
                chain_q <= {tdi_i, chain_q[N-1:1]};
            end else if (cap_i) begin
                chain_q <= lane_q;
            end
            if (upd_i) begin
                lane_q <= chain_q;
            end
        end
    end

    assign tdo_o = byp_i ? byp_stage_q : chain_q[0];

    // R9: a bypassed group keeps its chain and lane state
    p_byp_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byp_i |=> $stable(chain_q))
        else $error("bypassed chain changed");

    p_byp_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byp_i |=> $stable(lane_q))
        else $error("bypassed lane state changed");

endmodule

// File: rtl/chain_cmd_fsm.sv
module chain_cmd_fsm
    import chain_pkg::*;
#(
    parameter int GROUPS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_we_i,
    input  logic [CMD_W-1:0]      cmd_wdata_i,
    input  logic                  tick_i,
    input  logic                  ret_bit_i,
    output chain_state_e          state_o,
    output logic [REG_DATA_W-1:0] shreg_o,
    output logic [REG_CNT_W-1:0]  count_o,
    output logic [GROUPS-1:0]     sel_o,
    output logic                  tdi_o,
    output logic                  shift_stb_o,
    output logic                  cap_stb_o,
    output logic                  upd_stb_o
);

    chain_state_e          state_q, state_n;
    logic [REG_DATA_W-1:0] shreg_q;
    logic [REG_CNT_W-1:0]  count_q;
    logic [REG_CNT_W-1:0]  left_q;
    logic [GROUPS-1:0]     sel_q;
    logic [2:0]            req;
    logic                  start_ok;
    chain_state_e          req_state;
    logic                  unused_cmd;

    assign unused_cmd = ^cmd_wdata_i;
    assign req = {cmd_wdata_i[CMD_UPD_BIT], cmd_wdata_i[CMD_CAP_BIT], cmd_wdata_i[CMD_SHF_BIT]};

    always_comb begin
        start_ok  = 1'b0;
        req_state = ST_IDLE;
        if (cmd_we_i) begin
            unique case (req)
                3'b001:  begin start_ok = 1'b1; req_state = ST_SHIFT;   end
                3'b010:  begin start_ok = 1'b1; req_state = ST_CAPTURE; end
                3'b100:  begin start_ok = 1'b1; req_state = ST_UPDATE;  end
                default: begin start_ok = 1'b0; req_state = ST_IDLE;    end
            endcase
        end
    end

    // next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_ok) state_n = req_state;
            ST_SHIFT:   if (tick_i && (left_q == '0)) state_n = ST_IDLE;
            ST_CAPTURE: if (tick_i) state_n = ST_IDLE;
            ST_UPDATE:  if (tick_i) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            count_q <= '0;
            left_q  <= '0;
            sel_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start_ok) begin
                shreg_q <= cmd_wdata_i[REG_DATA_W-1:0];
                count_q <= cmd_wdata_i[CMD_CNT_LSB +: REG_CNT_W];
                left_q  <= cmd_wdata_i[CMD_CNT_LSB +: REG_CNT_W];
                sel_q   <= cmd_wdata_i[CMD_SEL_LSB +: GROUPS];
            end
        end else if ((state_q == ST_SHIFT) && tick_i) begin
            shreg_q <= {ret_bit_i, shreg_q[REG_DATA_W-1:1]};
            left_q  <= left_q - REG_CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        shift_stb_o = 1'b0;
        cap_stb_o   = 1'b0;
        upd_stb_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SHIFT:   shift_stb_o = tick_i;
            ST_CAPTURE: cap_stb_o   = tick_i;
            ST_UPDATE:  upd_stb_o   = tick_i;
            default:    ;
        endcase
    end

    assign state_o = state_q;
    assign shreg_o = shreg_q;
    assign count_o = count_q;
    assign sel_o   = sel_q;
    assign tdi_o   = shreg_q[0];

    // R3: the last counted shift ends the operation
    p_shift_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && tick_i && left_q == '0) |=> (state_q == ST_IDLE))
        else $error("shift did not finish");

    // R6/R7: capture and update last a single serial period
    p_single_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb_o || upd_stb_o) |=> (state_q == ST_IDLE))
        else $error("capture/update overran");

    // R10: command writes while busy do not reach the register
    p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cmd_we_i) |=> ($stable(count_q) && $stable(sel_q)))
        else $error("busy command write accepted");

endmodule

// File: rtl/chain_cmd_engine.sv
module chain_cmd_engine
    import chain_pkg::*;
#(
    parameter int LANE_BITS = 268,
    parameter int LANES     = 4,
    parameter int GROUPS    = 2,
    parameter int DIV_W     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        cmd_we,
    input  logic [63:0] cmd_wdata,
    output logic [31:0] cfg_rdata,
    output logic [63:0] cmd_rdata,
    output logic        sclk
);

    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int GPAD   = 1 << GSEL_W;

    chain_state_e          state;
    logic [REG_DATA_W-1:0] shreg;
    logic [REG_CNT_W-1:0]  count;
    logic [GROUPS-1:0]     sel;
    logic                  tdi, ret_bit, tick;
    logic                  shift_stb, cap_stb, upd_stb;
    logic [DIV_W-1:0]      div_q;
    logic [GSEL_W-1:0]     mux_q;
    logic [GROUPS-1:0]     byp_q;
    logic [GROUPS-1:0]     tdo;
    logic [GPAD-1:0]       tdo_pad;
    logic [7:0]            sel8, byp8;
    logic [3:0]            mux4;
    logic                  unused_cfg;

    assign unused_cfg = ^cfg_wdata;

    // configuration register, frozen while busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            mux_q <= '0;
            byp_q <= '0;
        end else if (cfg_we && (state == ST_IDLE)) begin
            div_q <= cfg_wdata[DIV_W-1:0];
            mux_q <= cfg_wdata[CFG_MUX_LSB +: GSEL_W];
            byp_q <= cfg_wdata[CFG_BYP_LSB +: GROUPS];
        end
    end

    chain_cmd_fsm #(.GROUPS(GROUPS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we_i    (cmd_we),
        .cmd_wdata_i (cmd_wdata),
        .tick_i      (tick),
        .ret_bit_i   (ret_bit),
        .state_o     (state),
        .shreg_o     (shreg),
        .count_o     (count),
        .sel_o       (sel),
        .tdi_o       (tdi),
        .shift_stb_o (shift_stb),
        .cap_stb_o   (cap_stb),
        .upd_stb_o   (upd_stb)
    );

    serial_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state != ST_IDLE),
        .div_i  (div_q),
        .tick_o (tick),
        .sclk_o (sclk)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        lane_group_chain #(.LANE_BITS(LANE_BITS), .LANES(LANES)) u_chain (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift_i (shift_stb & sel[g]),
            .cap_i   (cap_stb & sel[g]),
            .upd_i   (upd_stb & sel[g]),
            .byp_i   (byp_q[g]),
            .tdi_i   (tdi),
            .tdo_o   (tdo[g])
        );
    end

    always_comb begin
        tdo_pad = '0;
        tdo_pad[GROUPS-1:0] = tdo;
        ret_bit = tdo_pad[mux_q];
    end

    // read-back
    always_comb begin
        sel8 = '0;
        sel8[GROUPS-1:0] = sel;
        byp8 = '0;
        byp8[GROUPS-1:0] = byp_q;
        mux4 = '0;
        mux4[GSEL_W-1:0] = mux_q;
        cfg_rdata = '0;
        cfg_rdata[DIV_W-1:0] = div_q;
        cfg_rdata[CFG_MUX_LSB +: 4] = mux4;
        cfg_rdata[CFG_BYP_LSB +: 8] = byp8;
        cmd_rdata = '0;
        cmd_rdata[REG_DATA_W-1:0] = shreg;
        cmd_rdata[CMD_CNT_LSB +: REG_CNT_W] = count;
        cmd_rdata[CMD_SHF_BIT] = (state == ST_SHIFT);
        cmd_rdata[CMD_CAP_BIT] = (state == ST_CAPTURE);
        cmd_rdata[CMD_UPD_BIT] = (state == ST_UPDATE);
        cmd_rdata[CMD_SEL_LSB +: 8] = sel8;
    end

    // R2: serial clock idles low
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sclk)
        else $error("serial clock high while idle");

    // R10: configuration stays put through an operation
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |->
            ($stable(div_q) && $stable(mux_q) && $stable(byp_q)))
        else $error("configuration changed while busy");

    initial begin
        p_groups_fit: assert (GROUPS >= 1 && GROUPS <= MAX_GROUPS);
    end

endmodule

// File: tb/chain_cmd_engine_test.sv
module chain_cmd_engine_test;

    localparam int G  = 2;
    localparam int LB = 3;
    localparam int LN = 4;
    localparam int N  = LB * LN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cmd_we = 1'b0;
    logic [63:0] cmd_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] cmd_rdata;
    logic        sclk;

    chain_cmd_engine #(.LANE_BITS(LB), .LANES(LN), .GROUPS(G), .DIV_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cfg_rdata(cfg_rdata),
        .cmd_rdata(cmd_rdata), .sclk(sclk)
    );

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_st, m_ph, m_left, m_div, m_mux, m_cnt;
    bit [31:0] m_sh;
    bit [G-1:0] m_sel, m_byp;
    bit       mbp [G];
    bit       mch [G][$];
    bit       mln [G][$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_left = 0; m_div = 0; m_mux = 0; m_cnt = 0;
            m_sh = 0; m_sel = 0; m_byp = 0;
            for (int g = 0; g < G; g++) begin
                mbp[g] = 0;
                mch[g].delete();
                mln[g].delete();
                for (int i = 0; i < N; i++) begin
                    mch[g].push_back(1'b0);
                    mln[g].push_back((i % 3) == 0);
                end
            end
        end else if (m_st != 0) begin
            int p;
            p = 1 << (m_div + 2);
            if (m_ph == p - 1) begin
                m_ph = 0;
                if (m_st == 1) begin
                    bit o, r;
                    o = m_sh[0];
                    r = m_byp[m_mux] ? mbp[m_mux] : mch[m_mux][0];
                    for (int g = 0; g < G; g++) begin
                        if (m_sel[g]) begin
                            if (m_byp[g]) mbp[g] = o;
                            else begin
                                void'(mch[g].pop_front());
                                mch[g].push_back(o);
                            end
                        end
                    end
                    m_sh = {r, m_sh[31:1]};
                    if (m_left == 0) m_st = 0; else m_left--;
                end else begin
                    for (int g = 0; g < G; g++) begin
                        if (m_sel[g] && !m_byp[g]) begin
                            if (m_st == 2) mch[g] = mln[g];
                            else mln[g] = mch[g];
                        end
                    end
                    m_st = 0;
                end
            end else begin
                m_ph++;
            end
        end else begin
            if (cfg_we) begin
                m_div = int'(cfg_wdata[2:0]);
                m_mux = int'(cfg_wdata[4]);
                m_byp = cfg_wdata[9:8];
            end
            if (cmd_we) begin
                int k;
                k = cmd_wdata[40] + cmd_wdata[41] + cmd_wdata[42];
                if (k == 1) begin
                    m_sh = cmd_wdata[31:0];
                    m_cnt = int'(cmd_wdata[36:32]);
                    m_left = m_cnt;
                    m_sel = cmd_wdata[49:48];
                    m_ph = 0;
                    m_st = cmd_wdata[40] ? 1 : (cmd_wdata[41] ? 2 : 3);
                end
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [63:0] ec;
            logic [31:0] ef;
            int p;
            p = 1 << (m_div + 2);
            ec = '0;
            ec[31:0] = m_sh;
            ec[36:32] = 5'(m_cnt);
            ec[40] = (m_st == 1);
            ec[41] = (m_st == 2);
            ec[42] = (m_st == 3);
            ec[49:48] = m_sel;
            ef = '0;
            ef[2:0] = 3'(m_div);
            ef[4] = m_mux[0];
            ef[9:8] = m_byp;
            chk("R2 sclk", {63'b0, sclk}, {63'b0, (m_st != 0) && (m_ph >= p / 2)});
            chk("R3 request bits", {61'b0, cmd_rdata[42:40]}, {61'b0, ec[42:40]});
            chk("R4 working register", cmd_rdata, ec);
            chk("R10 config readback", {32'b0, cfg_rdata}, {32'b0, ef});
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] cfgw(int div, int mux, int byp);
        return 32'(div) | (32'(mux) << 4) | (32'(byp) << 8);
    endfunction

    function automatic logic [63:0] cmdw(int req, int cnt, logic [31:0] data, int sel);
        return {32'b0, data} | (64'(cnt) << 32) | (64'(req) << 40) | (64'(sel) << 48);
    endfunction

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_cmd(input logic [63:0] v);
        cmd_wdata = v; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle(output int busy, output int high);
        busy = 0; high = 0;
        while (cmd_rdata[42:40] != 3'b000 && busy < 20000) begin
            busy++;
            if (sclk) high++;
            @(negedge clk);
        end
        if (busy >= 20000) chk("R3 operation timeout", 64'(busy), 64'd0);
    endtask

    task automatic run(input int req, input int cnt, input logic [31:0] data,
                       input int sel, output logic [31:0] res);
        int b, h;
        wr_cmd(cmdw(req, cnt, data, sel));
        wait_idle(b, h);
        res = cmd_rdata[31:0];
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] r;
        logic [63:0] prev;
        int b, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg after reset", {32'b0, cfg_rdata}, 64'd0);
        chk("R1 cmd after reset", cmd_rdata, 64'd0);
        chk("R1 sclk after reset", {63'b0, sclk}, 64'd0);

        wr_cfg(cfgw(0, 0, 0));
        run(1, 11, 32'h0000_0ABC, 1, r);
        chk("R4 first fill returns zeros", {32'b0, r}, 64'h0);
        run(1, 11, 32'h0, 1, r);
        chk("R5 chain length and order", {32'b0, r}, 64'hABC0_0000);
        run(1, 3, 32'h1234_5678, 1, r);
        chk("R4 partial shift lower bits", {32'b0, r}, 64'h0123_4567);

        // capture of reset lane pattern
        run(2, 0, 32'h0, 1, r);
        run(1, 11, 32'h0, 1, r);
        chk("R6 R1 capture of lane seed", {32'b0, r}, 64'h2490_0000);
        // update then capture
        run(1, 11, 32'h0000_05A5, 1, r);
        run(4, 0, 32'h0, 1, r);
        run(1, 11, 32'h0, 1, r);
        chk("R7 chain after update", {32'b0, r}, 64'h5A50_0000);
        run(2, 0, 32'h0, 1, r);
        run(1, 11, 32'h0, 1, r);
        chk("R7 lane state after update", {32'b0, r}, 64'h5A50_0000);

        // group selection and return selector
        run(1, 11, 32'h0000_03C3, 1, r);
        run(1, 11, 32'h0000_0FFF, 2, r);
        wr_cfg(cfgw(0, 1, 0));
        run(1, 11, 32'h0, 2, r);
        chk("R8 group 1 via selector", {32'b0, r}, 64'hFFF0_0000);
        wr_cfg(cfgw(0, 0, 0));
        run(1, 11, 32'h0, 1, r);
        chk("R8 group 0 untouched", {32'b0, r}, 64'h3C30_0000);

        // bypass
        run(1, 11, 32'h0000_0777, 1, r);
        wr_cfg(cfgw(0, 0, 1));
        run(1, 3, 32'h0000_000F, 1, r);
        chk("R9 one-bit bypass stage", {32'b0, r}, 64'hE000_0000);
        run(4, 0, 32'h0, 1, r);
        wr_cfg(cfgw(0, 0, 0));
        run(1, 11, 32'h0, 1, r);
        chk("R9 bypassed chain kept", {32'b0, r}, 64'h7770_0000);

        // divider timing
        wr_cfg(cfgw(1, 0, 0));
        wr_cmd(cmdw(1, 2, 32'h5, 1));
        wait_idle(b, h);
        chk("R3 busy cycles div1 n3", 64'(b), 64'd24);
        chk("R2 sclk high cycles div1", 64'(h), 64'd12);
        wr_cfg(cfgw(2, 0, 0));
        wr_cmd(cmdw(2, 0, 32'h0, 1));
        wait_idle(b, h);
        chk("R2 capture period div2", 64'(b), 64'd16);
        chk("R2 sclk high cycles div2", 64'(h), 64'd8);

        // writes while busy
        wr_cfg(cfgw(1, 0, 0));
        wr_cmd(cmdw(1, 3, 32'h0000_00F0, 1));
        repeat (5) @(negedge clk);
        wr_cmd(cmdw(2, 9, 32'hDEAD_BEEF, 2));
        wr_cfg(cfgw(3, 1, 3));
        wait_idle(b, h);
        chk("R10 cfg unchanged", {32'b0, cfg_rdata}, {32'b0, cfgw(1, 0, 0)});
        chk("R10 count unchanged", {59'b0, cmd_rdata[36:32]}, 64'd3);
        chk("R10 data unchanged", {36'b0, cmd_rdata[27:0]}, 64'h000_000F);
        chk("R10 select unchanged", {62'b0, cmd_rdata[49:48]}, 64'd1);

        // malformed requests
        prev = cmd_rdata;
        wr_cmd(cmdw(3, 7, 32'hDEAD_BEEF, 2));
        chk("R11 two requests ignored", cmd_rdata, prev);
        wr_cmd(cmdw(0, 7, 32'hDEAD_BEEF, 2));
        chk("R11 no request ignored", cmd_rdata, prev);
        wr_cmd(cmdw(7, 1, 32'h1, 1));
        chk("R11 three requests ignored", cmd_rdata, prev);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule